// File: doc/BRIEF.md
# Load/Store Port Requester

This block sits between a compute unit and a memory-side buffer. It takes one command at a time from the core: a start pulse, a load or store selector, an address and, for stores, the data to write. It then drives the request side of a load/store port. That port is not fire-and-forget: the responder answers with a busy level and single-cycle pulses. The requester holds its request steady until the transaction has completed, and then gives the core a single done pulse. The pulse carries the loaded word, a store-complete flag or an exception flag.

The port follows strict hold-until-not-busy rules. Only one request kind is raised at a time, and never while busy is high. The address and its valid flag appear together and stay put until busy is seen low. The responder acknowledges or rejects the address with a one-cycle pulse. A load finishes on a one-cycle data strobe. A store sends its data with a one-cycle strobe only after the address acknowledge, and busy falls one cycle later with no write acknowledge. An abort input drops everything back to idle on the next clock.

Top module: `ldst_requester`

## Requirements
- R1: After reset the block is idle: `port_ld_req_o`, `port_st_req_o`, `port_addr_vld_o`, `port_st_stb_o` and `done_o` are 0, and `cmd_ready_o` is 1 while `port_busy_i` is 0.
- R2: A start is taken only while the block is idle and `port_busy_i` is 0. A start presented while busy is high raises no request and no address-valid, and `cmd_ready_o` is 0 in that time.
- R3: The clock edge that takes a start raises exactly one request line: `port_st_req_o` when `cmd_store_i` was 1, otherwise `port_ld_req_o`. The two lines are never high together.
- R4: `port_addr_vld_o` rises together with the request and carries the command address on `port_addr_o`. Both stay high and constant without a gap. They fall on the clock edge after the first cycle of the completion in which `port_busy_i` is seen low.
- R5: An address-exception pulse, while the block waits for the address reply, ends the command. `done_o` and `done_exc_o` are high in the next cycle, `done_store_o` is 0, no store strobe is sent, and the block returns to idle.
- R6: For a load, the word on `port_ld_data_i` in the cycle `port_ld_vld_i` is high is captured. `done_o` is high in the next cycle with that word on `done_rdata_o` and both flags 0. The word stays on `done_rdata_o` after the pulse.
- R7: For a store, `port_st_stb_o` is high for exactly one cycle: the cycle after the address-acknowledge pulse. In that cycle `port_st_data_o` equals the command's store data.
- R8: For a store, `done_o` and `done_store_o` are high in the cycle after the first cycle following the strobe in which `port_busy_i` is low. With a responder that drops busy one cycle after the strobe, this is two cycles after the strobe.
- R9: `abort_i` high at a clock edge makes every request line and `port_addr_vld_o` 0 after that edge, and no done pulse follows for the aborted command. The next command completes normally.
- R10: `done_o` is high for exactly one cycle per completed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Drop the current command and return to idle |
| cmd_start_i | input | 1 | Core requests a new command |
| cmd_store_i | input | 1 | 1 = store, 0 = load |
| cmd_addr_i | input | ADDR_W | Command address |
| cmd_wdata_i | input | DATA_W | Store data |
| cmd_ready_o | output | 1 | Idle and port not busy; a start is taken |
| done_o | output | 1 | One-cycle completion pulse |
| done_store_o | output | 1 | With done: store completed |
| done_exc_o | output | 1 | With done: address exception |
| done_rdata_o | output | DATA_W | Last loaded word |
| port_busy_i | input | 1 | Responder busy |
| port_addr_ack_i | input | 1 | One-cycle address acknowledge |
| port_addr_exc_i | input | 1 | One-cycle address exception |
| port_ld_vld_i | input | 1 | One-cycle load data strobe |
| port_ld_data_i | input | DATA_W | Load data |
| port_ld_req_o | output | 1 | Load request |
| port_st_req_o | output | 1 | Store request |
| port_addr_vld_o | output | 1 | Address valid |
| port_addr_o | output | ADDR_W | Address |
| port_st_stb_o | output | 1 | One-cycle store strobe |
| port_st_data_o | output | DATA_W | Store data |

## Verification
A wrong state shows at the ports within one cycle, because every request line, the address-valid flag and the store strobe are decoded directly from the state register. A state that enters the store send early puts the strobe on the port before or without the acknowledge. A state that misses the wait-for-not-busy step drops address-valid while busy is still high, or never reports store completion. A done decision in the wrong place shows up one cycle later as a done pulse in the wrong cycle or with the wrong flags. The bench therefore records, for every command, the cycle of each request, pulse and strobe. It then compares those cycle numbers and the returned data with what the handshake rules dictate, using several responder latencies.

// File: rtl/ldst_req_pkg.sv
package ldst_req_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_ACK,
        ST_WAIT_LD,
        ST_SEND_ST,
        ST_WAIT_FREE
    } req_state_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_LOAD,
        EV_STORE,
        EV_EXC
    } req_event_e;

    function automatic logic holds_port(req_state_e s);
        return s != ST_IDLE;
    endfunction

endpackage

// File: rtl/ldst_req_fsm.sv
module ldst_req_fsm
    import ldst_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       abort_i,
    input  logic       start_i,
    input  logic       store_i,
    input  logic       busy_i,
    input  logic       ack_i,
    input  logic       exc_i,
    input  logic       ld_vld_i,
    output req_state_e state_o,
    output logic       is_store_o,
    output logic       accept_o,
    output req_event_e event_o
);

    req_state_e state_q, state_d;
    logic       store_q;
    logic       st_owed_q;

    always_comb begin
        state_d  = state_q;
        event_o  = EV_NONE;
        accept_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && !busy_i) begin
                    accept_o = 1'b1;
                    state_d  = ST_WAIT_ACK;
                end
            end
            ST_WAIT_ACK: begin
                if (exc_i) begin
                    event_o = EV_EXC;
                    state_d = busy_i ? ST_WAIT_FREE : ST_IDLE;
                end else if (ack_i) begin
                    state_d = store_q ? ST_SEND_ST : ST_WAIT_LD;
                end
            end
            ST_WAIT_LD: begin
                if (ld_vld_i) begin
                    event_o = EV_LOAD;
                    state_d = busy_i ? ST_WAIT_FREE : ST_IDLE;
                end
            end
            ST_SEND_ST: begin
                state_d = ST_WAIT_FREE;
            end
            ST_WAIT_FREE: begin
                if (!busy_i) begin
                    state_d = ST_IDLE;
                    if (st_owed_q) event_o = EV_STORE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort_i) begin
            state_d  = ST_IDLE;
            event_o  = EV_NONE;
            accept_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            store_q   <= 1'b0;
            st_owed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept_o) store_q <= store_i;
            if (state_q == ST_SEND_ST && !abort_i) st_owed_q <= 1'b1;
            else if (state_d == ST_IDLE)           st_owed_q <= 1'b0;
        end
    end

    assign state_o    = state_q;
    assign is_store_o = store_q;

endmodule

// File: rtl/ldst_req_hold.sv
module ldst_req_hold
    import ldst_req_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    input  req_event_e        event_i,
    input  logic [DATA_W-1:0] ld_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              done_o,
    output logic              done_store_o,
    output logic              done_exc_o,
    output logic [DATA_W-1:0] rdata_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o       <= '0;
            wdata_o      <= '0;
            done_o       <= 1'b0;
            done_store_o <= 1'b0;
            done_exc_o   <= 1'b0;
            rdata_o      <= '0;
        end else begin
            if (accept_i) begin
                addr_o  <= cmd_addr_i;
                wdata_o <= cmd_wdata_i;
            end
            done_o       <= (event_i != EV_NONE);
            done_store_o <= (event_i == EV_STORE);
            done_exc_o   <= (event_i == EV_EXC);
            if (event_i == EV_LOAD) rdata_o <= ld_data_i;
        end
    end

endmodule

// File: rtl/ldst_requester.sv
module ldst_requester
    import ldst_req_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort_i,
    input  logic              cmd_start_i,
    input  logic              cmd_store_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    output logic              cmd_ready_o,
    output logic              done_o,
    output logic              done_store_o,
    output logic              done_exc_o,
    output logic [DATA_W-1:0] done_rdata_o,
    input  logic              port_busy_i,
    input  logic              port_addr_ack_i,
    input  logic              port_addr_exc_i,
    input  logic              port_ld_vld_i,
    input  logic [DATA_W-1:0] port_ld_data_i,
    output logic              port_ld_req_o,
    output logic              port_st_req_o,
    output logic              port_addr_vld_o,
    output logic [ADDR_W-1:0] port_addr_o,
    output logic              port_st_stb_o,
    output logic [DATA_W-1:0] port_st_data_o
);

    req_state_e state;
    req_event_e event_now;
    logic       is_store;
    logic       accept;
    logic       active;

    ldst_req_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .abort_i   (abort_i),
        .start_i   (cmd_start_i),
        .store_i   (cmd_store_i),
        .busy_i    (port_busy_i),
        .ack_i     (port_addr_ack_i),
        .exc_i     (port_addr_exc_i),
        .ld_vld_i  (port_ld_vld_i),
        .state_o   (state),
        .is_store_o(is_store),
        .accept_o  (accept),
        .event_o   (event_now)
    );

    ldst_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk         (clk),
        .rst         (rst),
        .accept_i    (accept),
        .cmd_addr_i  (cmd_addr_i),
        .cmd_wdata_i (cmd_wdata_i),
        .event_i     (event_now),
        .ld_data_i   (port_ld_data_i),
        .addr_o      (port_addr_o),
        .wdata_o     (port_st_data_o),
        .done_o      (done_o),
        .done_store_o(done_store_o),
        .done_exc_o  (done_exc_o),
        .rdata_o     (done_rdata_o)
    );

    assign active          = holds_port(state);
    assign port_ld_req_o   = active && !is_store;
    assign port_st_req_o   = active && is_store;
    assign port_addr_vld_o = active;
    assign port_st_stb_o   = (state == ST_SEND_ST);
    assign cmd_ready_o     = (state == ST_IDLE) && !port_busy_i;

endmodule

// File: rtl/ldst_requester_chk.sv
module ldst_requester_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              abort_i,
    input logic              busy_i,
    input logic              ack_i,
    input logic              exc_i,
    input logic              ld_vld_i,
    input logic              ld_req_o,
    input logic              st_req_o,
    input logic              addr_vld_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              st_stb_o,
    input logic              done_o,
    input logic              done_store_o,
    input logic              done_exc_o
);

    // R3: never both request kinds
    a_r3_one_kind: assert property (@(posedge clk) disable iff (rst)
        !(ld_req_o && st_req_o));

    // R2: a new address is never raised after a busy cycle
    a_r2_no_req_when_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_vld_o) |-> !$past(busy_i));

    // R4: address held steady while valid stays up
    a_r4_addr_steady: assert property (@(posedge clk) disable iff (rst)
        (addr_vld_o && $past(addr_vld_o)) |-> $stable(addr_o));

    // R7: store strobe follows an acknowledge and lasts one cycle
    a_r7_stb_after_ack: assert property (@(posedge clk) disable iff (rst)
        st_stb_o |-> $past(ack_i));
    a_r7_stb_single: assert property (@(posedge clk) disable iff (rst)
        st_stb_o |=> !st_stb_o);

    // R5: exception flag only right after an exception pulse
    a_r5_exc_source: assert property (@(posedge clk) disable iff (rst)
        (done_o && done_exc_o) |-> $past(exc_i));

    // R6: load completion only right after a load strobe
    a_r6_ld_source: assert property (@(posedge clk) disable iff (rst)
        (done_o && !done_exc_o && !done_store_o) |-> $past(ld_vld_i));

    // R9: abort clears the port
    a_r9_abort_clears: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (!ld_req_o && !st_req_o && !addr_vld_o));

    // R10: done lasts a single cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

bind ldst_requester ldst_requester_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .abort_i     (abort_i),
    .busy_i      (port_busy_i),
    .ack_i       (port_addr_ack_i),
    .exc_i       (port_addr_exc_i),
    .ld_vld_i    (port_ld_vld_i),
    .ld_req_o    (port_ld_req_o),
    .st_req_o    (port_st_req_o),
    .addr_vld_o  (port_addr_vld_o),
    .addr_o      (port_addr_o),
    .st_stb_o    (port_st_stb_o),
    .done_o      (done_o),
    .done_store_o(done_store_o),
    .done_exc_o  (done_exc_o)
);

// File: tb/tb_ldst_requester.sv
module tb_ldst_requester;

    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          abort_i = 1'b0;
    logic          cmd_start = 1'b0;
    logic          cmd_store = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          cmd_ready, done, done_store, done_exc;
    logic [DW-1:0] done_rdata;
    logic          p_busy, p_ack, p_exc, p_ldv;
    logic [DW-1:0] p_ldd;
    logic          p_ldreq, p_streq, p_vld, p_stb;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_std;

    ldst_requester #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .abort_i(abort_i),
        .cmd_start_i(cmd_start), .cmd_store_i(cmd_store),
        .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
        .cmd_ready_o(cmd_ready), .done_o(done), .done_store_o(done_store),
        .done_exc_o(done_exc), .done_rdata_o(done_rdata),
        .port_busy_i(p_busy), .port_addr_ack_i(p_ack), .port_addr_exc_i(p_exc),
        .port_ld_vld_i(p_ldv), .port_ld_data_i(p_ldd),
        .port_ld_req_o(p_ldreq), .port_st_req_o(p_streq),
        .port_addr_vld_o(p_vld), .port_addr_o(p_addr),
        .port_st_stb_o(p_stb), .port_st_data_o(p_std)
    );

    // ---------------- behavioural responder ----------------
    localparam int R_IDLE = 0, R_ADDR = 1, R_LD = 2, R_ST = 3, R_DONE = 4;
    int            rs;
    int            cnt;
    int            ack_dly = 0;
    int            ld_dly = 0;
    logic          exc_mode = 1'b0;
    logic          force_busy = 1'b0;
    logic          resp_clear = 1'b0;
    logic [DW-1:0] mem [16];
    logic [DW-1:0] shadow [16];

    function automatic logic [DW-1:0] init_word(int i);
        return 32'hA500_0000 | (i * 32'h0000_0101);
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i]    = init_word(i);
            shadow[i] = init_word(i);
        end
    end

    assign p_ack  = (rs == R_ADDR) && (cnt == 0) && !exc_mode;
    assign p_exc  = (rs == R_ADDR) && (cnt == 0) && exc_mode;
    assign p_ldv  = (rs == R_LD) && (cnt == 0);
    assign p_ldd  = p_ldv ? mem[p_addr[3:0]] : 32'hDEAD_0000;
    assign p_busy = force_busy ||
                    ((rs == R_ADDR || rs == R_LD || rs == R_ST) && !p_exc && !p_ldv);

    always @(posedge clk) begin
        if (rst || resp_clear) begin
            rs  <= R_IDLE;
            cnt <= 0;
        end else begin
            case (rs)
                R_IDLE: if (p_ldreq || p_streq) begin rs <= R_ADDR; cnt <= ack_dly; end
                R_ADDR: begin
                    if (cnt != 0)      cnt <= cnt - 1;
                    else if (exc_mode) rs <= R_DONE;
                    else if (p_ldreq)  begin rs <= R_LD; cnt <= ld_dly; end
                    else               rs <= R_ST;
                end
                R_LD: begin
                    if (cnt != 0) cnt <= cnt - 1;
                    else          rs <= R_DONE;
                end
                R_ST: if (p_stb) begin mem[p_addr[3:0]] <= p_std; rs <= R_DONE; end
                R_DONE: if (!(p_ldreq || p_streq)) rs <= R_IDLE;
                default: rs <= R_IDLE;
            endcase
        end
    end

    // ---------------- bookkeeping ----------------
    int checks = 0;
    int failures = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog run did not finish actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // observations of one command
    int   o_req, o_ack, o_exc, o_ldv, o_stb, o_stb_cnt, o_done, o_done_cnt;
    int   o_vfirst, o_vlast;
    bit   o_gap, o_addr_bad, o_both, o_wrong_kind, o_store, o_excf;
    logic [DW-1:0] o_stb_data, o_rdata;

    task automatic run_op(input bit st, input logic [AW-1:0] a, input logic [DW-1:0] d);
        o_req = -1; o_ack = -1; o_exc = -1; o_ldv = -1; o_stb = -1; o_stb_cnt = 0;
        o_done = -1; o_done_cnt = 0; o_vfirst = -1; o_vlast = -1;
        o_gap = 0; o_addr_bad = 0; o_both = 0; o_wrong_kind = 0; o_store = 0; o_excf = 0;
        o_stb_data = '0; o_rdata = '0;
        @(negedge clk);
        cmd_start = 1'b1; cmd_store = st; cmd_addr = a; cmd_wdata = d;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (k == 1) cmd_start = 1'b0;
            if (p_ldreq && p_streq) o_both = 1;
            if ((p_ldreq || p_streq) && o_req < 0) begin
                o_req = k;
                if (st ? !p_streq : !p_ldreq) o_wrong_kind = 1;
            end
            if (p_vld) begin
                if (o_vfirst < 0) o_vfirst = k;
                else if (o_vlast != k - 1) o_gap = 1;
                o_vlast = k;
                if (p_addr != a) o_addr_bad = 1;
            end
            if (p_ack && o_ack < 0) o_ack = k;
            if (p_exc && o_exc < 0) o_exc = k;
            if (p_ldv && o_ldv < 0) o_ldv = k;
            if (p_stb) begin o_stb_cnt++; o_stb = k; o_stb_data = p_std; end
            if (done) begin
                o_done_cnt++;
                if (o_done < 0) begin
                    o_done = k; o_store = done_store; o_excf = done_exc; o_rdata = done_rdata;
                end
            end
            if (o_done > 0 && k >= o_done + 3) break;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(!p_ldreq && !p_streq, "R1", "request lines after reset", {p_ldreq, p_streq}, 0);
        check(!p_vld, "R1", "addr valid after reset", p_vld, 0);
        check(!p_stb, "R1", "store strobe after reset", p_stb, 0);
        check(!done, "R1", "done after reset", done, 0);
        check(cmd_ready, "R1", "ready after reset", cmd_ready, 1);
    endtask

    task automatic t_load(input logic [AW-1:0] a, input int ad, input int ld);
        ack_dly = ad; ld_dly = ld; exc_mode = 1'b0;
        run_op(1'b0, a, '0);
        check(o_req == 1 && !o_wrong_kind && !o_both, "R3", "load request cycle", o_req, 1);
        check(o_vfirst == 1 && !o_gap && !o_addr_bad && o_vlast == o_done - 1, "R4",
              "load addr valid window end", o_vlast, o_done - 1);
        check(o_ldv > 0 && o_done == o_ldv + 1, "R6", "load done cycle", o_done, o_ldv + 1);
        check(o_rdata == shadow[a[3:0]] && !o_store && !o_excf, "R6", "load data",
              o_rdata, shadow[a[3:0]]);
        check(done_rdata == shadow[a[3:0]], "R6", "load data held", done_rdata, shadow[a[3:0]]);
        check(o_done_cnt == 1, "R10", "load done pulse count", o_done_cnt, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input int ad);
        ack_dly = ad; exc_mode = 1'b0;
        run_op(1'b1, a, d);
        shadow[a[3:0]] = d;
        check(o_req == 1 && !o_wrong_kind && !o_both, "R3", "store request cycle", o_req, 1);
        check(o_stb_cnt == 1 && o_ack > 0 && o_stb == o_ack + 1, "R7", "strobe cycle",
              o_stb, o_ack + 1);
        check(o_stb_data == d, "R7", "strobe data", o_stb_data, d);
        check(o_done == o_stb + 2 && o_store && !o_excf, "R8", "store done cycle",
              o_done, o_stb + 2);
        check(o_vfirst == 1 && !o_gap && !o_addr_bad && o_vlast == o_stb + 1, "R4",
              "store addr valid end", o_vlast, o_stb + 1);
        check(o_done_cnt == 1, "R10", "store done pulse count", o_done_cnt, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_exception(input bit st, input int ad);
        ack_dly = ad; exc_mode = 1'b1;
        run_op(st, 16'h0007, 32'h1234_5678);
        check(o_exc > 0 && o_done == o_exc + 1 && o_excf && !o_store, "R5",
              "exception done", o_done, o_exc + 1);
        check(o_stb_cnt == 0, "R5", "no strobe after exception", o_stb_cnt, 0);
        check(o_vlast == o_exc, "R4", "addr valid end at exception", o_vlast, o_exc);
        check(cmd_ready && !p_vld, "R5", "idle after exception", cmd_ready, 1);
        exc_mode = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_busy_block;
        bit seen_req = 0;
        bit got_done = 0;
        ack_dly = 0; ld_dly = 0;
        @(negedge clk);
        force_busy = 1'b1;
        cmd_start = 1'b1; cmd_store = 1'b0; cmd_addr = 16'h0003;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (p_ldreq || p_streq || p_vld) seen_req = 1;
        end
        check(!seen_req, "R2", "request raised while busy", seen_req, 0);
        check(!cmd_ready, "R2", "ready while busy", cmd_ready, 0);
        force_busy = 1'b0;
        @(negedge clk);
        cmd_start = 1'b0;
        check(p_ldreq && p_vld, "R2", "request after busy released", p_ldreq, 1);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (done) got_done = 1;
        end
        check(got_done, "R2", "command after busy completes", got_done, 1);
    endtask

    task automatic t_abort;
        bit extra_done = 0;
        ack_dly = 6;
        @(negedge clk);
        cmd_start = 1'b1; cmd_store = 1'b1; cmd_addr = 16'h0009; cmd_wdata = 32'hFFFF_0001;
        @(negedge clk);
        cmd_start = 1'b0;
        @(negedge clk);
        check(p_streq && p_vld, "R9", "request before abort", p_streq, 1);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        check(!p_ldreq && !p_streq && !p_vld && !p_stb, "R9", "port after abort",
              {p_ldreq, p_streq, p_vld, p_stb}, 0);
        resp_clear = 1'b1;
        @(negedge clk);
        resp_clear = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (done || p_stb) extra_done = 1;
        end
        check(!extra_done, "R9", "done or strobe after abort", extra_done, 0);
        check(cmd_ready, "R9", "ready after abort", cmd_ready, 1);
        t_load(16'h0009, 0, 0);
        check(o_done > 0, "R9", "next command completes after abort", o_done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load(16'h0002, 0, 0);
        t_load(16'h000C, 3, 4);
        t_store(16'h0002, 32'h0000_BEEF, 0);
        t_load(16'h0002, 1, 2);
        t_store(16'h000E, 32'hC0FF_EE01, 4);
        t_load(16'h000E, 0, 5);
        t_exception(1'b0, 0);
        t_exception(1'b1, 3);
        t_busy_block();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule